// File: doc/BRIEF.md
# Result-Write-Bit Execute Unit

This block is the execute and writeback stage of a 32-bit processor whose instructions name two register-file operands. Each cycle it may receive one instruction word, together with the destination operand value read from the register file, the source register value, the program counter and the current hub read data. It computes the result, the next zero and carry flags and the register-file write request. A single result-write bit in the instruction decides whether that result is stored. The same operation code therefore acts as a pair of instructions: compare or subtract, test or AND, test-not or AND-NOT, jump or jump-and-link, hub write or hub read.

The writeback request and the flags are registered. They are visible on the cycle after the instruction is issued. Hub requests, the jump request and the pin-wait comparison are combinational outputs in the issue cycle.

The instruction word, from bit 31 down, holds these fields:
- op[31:26]
- zw[25], which writes Z
- cw[24], which writes C
- rw[23], which writes the result
- imm[22]
- cond[21:18]
- dst[17:9]
- src[8:0]

Top module: `rbit_exec_unit`

## Requirements
- R1: The condition passes when bit {C,Z} of cond is set, using bit index 2*C+Z and the current flags. So 4'b1111 always passes and 4'b0000 never does. A written result appears on rf_we, rf_waddr (= dst) and rf_wdata one clock after issue.
- R2: Operation codes 000000, 000001 and 000010 are the hub byte, word and long operations, and hub_size repeats their low two bits. With rw clear, hub_wr pulses with hub_addr equal to the low bits of S and hub_wdata equal to D, and no register is written. With rw set, hub_rd pulses and the zero-extended low 8, 16 or 32 bits of hub_rdata are written. The Z flag is set when the value is zero, and C becomes 0.
- R3: Operation code 100001 computes D-S. C is the unsigned borrow and Z is set when the difference is zero. With rw clear it is a compare and writes nothing.
- R4: Operation codes 011000 (D&S) and 011001 (D&~S) set Z when the result is zero and set C to the odd parity of the result. With rw clear they are tests.
- R5: Operation code 010111 raises jump_taken with jump_target = S[8:0] whenever the condition passes, whatever rw is. With rw set it writes {D[31:9], pc+1}, where pc+1 wraps in 9 bits. Z follows the written value and C becomes 0.
- R6: With rw set, the pin-equal wait (111100) and the video wait (111111) write D+S, and the pin-not-equal wait (111101) writes D+S+1. C is the carry out and Z is set when the sum is zero.
- R7: wait_hit compares the pin port selected by the carry flag (C=1 picks port B, C=0 picks port A) after masking it with S. For 111100 it is high when the masked value equals D. For 111101 it is high when the masked value differs from D. It is 0 for all other operations and when the condition fails.
- R8: Operation code 000011, the cog and lock control group, uses only D[2:0]. With rw set it writes that value zero-extended, sets Z when the value is zero, and sets C to 0.
- R9: With imm set, S is the zero-extended 9-bit src field and the source register input is ignored.
- R10: rf_we rises only for a valid instruction with rw set and a passing condition, so a clear rw never writes the register file. Z and C change only on a valid instruction with a passing condition and their own write bit set, and they hold otherwise.
- R11: After reset, flag_z, flag_c and rf_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction present this cycle |
| issue_instr | input | 32 | Instruction word |
| issue_pc | input | 9 | Address of the issued instruction |
| op_d | input | DW | Destination register value |
| op_s_reg | input | DW | Source register value |
| hub_rdata | input | DW | Hub read data |
| pin_a | input | DW | Input port A |
| pin_b | input | DW | Input port B |
| hub_wr | output | 1 | Hub write strobe |
| hub_rd | output | 1 | Hub read strobe |
| hub_size | output | 2 | 0 byte, 1 word, 2 long |
| hub_addr | output | HUB_AW | Hub address |
| hub_wdata | output | DW | Hub write data |
| jump_taken | output | 1 | Jump request |
| jump_target | output | 9 | Jump address |
| wait_hit | output | 1 | Pin wait condition met |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 9 | Register-file write address |
| rf_wdata | output | DW | Register-file write data |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench issues every paired operation code with rw both clear and set. A design that wrote on a compare, test, jump or hub write would show a stray rf_we. A design that dropped the read twin would show a missing write or the wrong zero-extension width. It targets the not-equal wait's extra increment and the carry out when the sum wraps to zero, and it checks the 9-bit return-address wrap, where an adder one bit too wide would corrupt D[9]. It also drives conditions that pass and fail on particular flag combinations, immediate operands with a garbage source register, carry-selected port B, and flag write bits left clear, where a design that updated flags without permission would show changed Z or C.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

  typedef struct packed {
    logic [5:0] op;
    logic       zw;
    logic       cw;
    logic       rw;
    logic       imm;
    logic [3:0] cond;
    logic [8:0] dst;
    logic [8:0] src;
  } rbx_instr_t;

  localparam int unsigned RADDR_W = 9;

  localparam logic [5:0] OP_HUBB = 6'b000000;
  localparam logic [5:0] OP_HUBW = 6'b000001;
  localparam logic [5:0] OP_HUBL = 6'b000010;
  localparam logic [5:0] OP_SYS  = 6'b000011;
  localparam logic [5:0] OP_LINK = 6'b010111;
  localparam logic [5:0] OP_AND  = 6'b011000;
  localparam logic [5:0] OP_ANDN = 6'b011001;
  localparam logic [5:0] OP_SUB  = 6'b100001;
  localparam logic [5:0] OP_WPEQ = 6'b111100;
  localparam logic [5:0] OP_WPNE = 6'b111101;
  localparam logic [5:0] OP_WVID = 6'b111111;

endpackage

// File: rtl/rbx_rst_sync.sv
module rbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/rbx_cond.sv
module rbx_cond (
  input  logic [3:0] cond,
  input  logic       z,
  input  logic       c,
  output logic       pass
);
  // Truth-table condition: one bit per (C,Z) combination.
  assign pass = cond[{c, z}];
endmodule

// File: rtl/rbx_alu.sv
module rbx_alu
  import rbx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [5:0]         op,
  input  logic [DW-1:0]      d,
  input  logic [DW-1:0]      s,
  input  logic [RADDR_W-1:0] pc,
  input  logic [DW-1:0]      hub_rdata,
  output logic [DW-1:0]      res,
  output logic               z_o,
  output logic               c_o
);
  localparam int unsigned HI_W = DW - RADDR_W;

  logic [DW:0]          add_w;
  logic [DW:0]          sub_w;
  logic [RADDR_W-1:0]   ret_pc;

  assign add_w  = {1'b0, d} + {1'b0, s} + {{DW{1'b0}}, (op == OP_WPNE)};
  assign sub_w  = {1'b0, d} - {1'b0, s};
  assign ret_pc = pc + {{(RADDR_W-1){1'b0}}, 1'b1};

  always_comb begin
    res = d;
    c_o = 1'b0;
    unique case (op)
      OP_HUBB: res = {{(DW-8){1'b0}}, hub_rdata[7:0]};
      OP_HUBW: res = {{(DW-16){1'b0}}, hub_rdata[15:0]};
      OP_HUBL: res = hub_rdata;
      OP_SYS:  res = {{(DW-3){1'b0}}, d[2:0]};
      OP_LINK: res = {d[DW-1 -: HI_W], ret_pc};
      OP_AND: begin
        res = d & s;
        c_o = ^(d & s);
      end
      OP_ANDN: begin
        res = d & ~s;
        c_o = ^(d & ~s);
      end
      OP_SUB: begin
        res = sub_w[DW-1:0];
        c_o = sub_w[DW];
      end
      OP_WPEQ, OP_WPNE, OP_WVID: begin
        res = add_w[DW-1:0];
        c_o = add_w[DW];
      end
      default: begin
        res = d;
        c_o = 1'b0;
      end
    endcase
  end

  assign z_o = (res == '0);
endmodule

// File: rtl/rbit_exec_unit.sv
module rbit_exec_unit
  import rbx_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned HUB_AW      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_valid,
  input  logic [31:0]          issue_instr,
  input  logic [RADDR_W-1:0]   issue_pc,
  input  logic [DW-1:0]        op_d,
  input  logic [DW-1:0]        op_s_reg,
  input  logic [DW-1:0]        hub_rdata,
  input  logic [DW-1:0]        pin_a,
  input  logic [DW-1:0]        pin_b,
  output logic                 hub_wr,
  output logic                 hub_rd,
  output logic [1:0]           hub_size,
  output logic [HUB_AW-1:0]    hub_addr,
  output logic [DW-1:0]        hub_wdata,
  output logic                 jump_taken,
  output logic [RADDR_W-1:0]   jump_target,
  output logic                 wait_hit,
  output logic                 rf_we,
  output logic [RADDR_W-1:0]   rf_waddr,
  output logic [DW-1:0]        rf_wdata,
  output logic                 flag_z,
  output logic                 flag_c
);
  localparam int unsigned IMM_PAD = DW - RADDR_W;

  rbx_instr_t ins;
  logic       srst_n;
  logic       pass;
  logic       fire;
  logic [DW-1:0] s_eff;
  logic [DW-1:0] alu_res;
  logic       alu_z, alu_c;
  logic       is_hub;
  logic [DW-1:0] port_sel;
  logic       port_eq;

  logic       we_d, we_q;
  logic [RADDR_W-1:0] waddr_q;
  logic [DW-1:0]      wdata_q;
  logic       z_d, z_q, c_d, c_q;

  assign ins = rbx_instr_t'(issue_instr);

  rbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rbx_cond u_cond (
    .cond (ins.cond),
    .z    (z_q),
    .c    (c_q),
    .pass (pass)
  );

  assign s_eff = ins.imm ? {{IMM_PAD{1'b0}}, ins.src} : op_s_reg;
  assign fire  = issue_valid & pass;

  rbx_alu #(.DW(DW)) u_alu (
    .op        (ins.op),
    .d         (op_d),
    .s         (s_eff),
    .pc        (issue_pc),
    .hub_rdata (hub_rdata),
    .res       (alu_res),
    .z_o       (alu_z),
    .c_o       (alu_c)
  );

  // Hub side: one code pair, direction chosen by the result-write bit.
  assign is_hub    = (ins.op[5:2] == 4'b0000) && (ins.op[1:0] != 2'b11);
  assign hub_wr    = fire & is_hub & ~ins.rw;
  assign hub_rd    = fire & is_hub &  ins.rw;
  assign hub_size  = ins.op[1:0];
  assign hub_addr  = s_eff[HUB_AW-1:0];
  assign hub_wdata = op_d;

  assign jump_taken  = fire & (ins.op == OP_LINK);
  assign jump_target = s_eff[RADDR_W-1:0];

  // Port selection by carry flag, not by an opcode bit.
  assign port_sel = c_q ? pin_b : pin_a;
  assign port_eq  = ((port_sel & s_eff) == op_d);
  assign wait_hit = fire & (((ins.op == OP_WPEQ) & port_eq) |
                            ((ins.op == OP_WPNE) & ~port_eq));

  // Next-state
  always_comb begin
    we_d = fire & ins.rw;
    z_d  = (fire & ins.zw) ? alu_z : z_q;
    c_d  = (fire & ins.cw) ? alu_c : c_q;
  end

  // Registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      z_q     <= 1'b0;
      c_q     <= 1'b0;
    end else begin
      we_q <= we_d;
      if (we_d) begin
        waddr_q <= ins.dst;
        wdata_q <= alu_res;
      end
      z_q <= z_d;
      c_q <= c_d;
    end
  end

  assign rf_we    = we_q;
  assign rf_waddr = waddr_q;
  assign rf_wdata = wdata_q;
  assign flag_z   = z_q;
  assign flag_c   = c_q;
endmodule

// File: rtl/rbx_chk.sv
module rbx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_valid,
  input logic [31:0] issue_instr,
  input logic        rf_we,
  input logic [8:0]  rf_waddr,
  input logic        flag_z,
  input logic        flag_c,
  input logic        hub_wr,
  input logic        hub_rd,
  input logic        wait_hit
);
  p_rw_clear_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_instr[23]) |=> !rf_we);

  p_idle_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> ($stable(flag_z) && $stable(flag_c)));

  p_never_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_instr[21:18] == 4'b0000) |=>
      (!rf_we && $stable(flag_z) && $stable(flag_c)));

  p_waddr_dst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr == $past(issue_instr[17:9])));

  p_hub_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hub_wr && hub_rd));

  p_hub_rd_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hub_rd |=> rf_we);

  p_hit_only_pinwait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_hit |-> (issue_instr[31:27] == 5'b11110));
endmodule

bind rbit_exec_unit rbx_chk u_chk (.*);

// File: tb/rbit_exec_unit_tb.sv
module rbit_exec_unit_tb;
  typedef struct {
    bit          we;
    bit [8:0]    addr;
    bit [31:0]   data;
    bit          z;
    bit          c;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [31:0] issue_instr;
  logic [8:0]  issue_pc;
  logic [31:0] op_d, op_s_reg, hub_rdata, pin_a, pin_b;
  logic        hub_wr, hub_rd, jump_taken, wait_hit, rf_we, flag_z, flag_c;
  logic [1:0]  hub_size;
  logic [15:0] hub_addr;
  logic [31:0] hub_wdata, rf_wdata;
  logic [8:0]  jump_target, rf_waddr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  exp_t q[$];
  bit ez = 0, ec = 0;

  always #4 clk = ~clk;

  rbit_exec_unit u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input bit zw, input bit cw,
                                     input bit rw, input bit imm, input logic [3:0] cond,
                                     input logic [8:0] dst, input logic [8:0] src);
    return {op, zw, cw, rw, imm, cond, dst, src};
  endfunction

  // Reference result from the requirements
  function automatic logic [33:0] model(input logic [5:0] op, input logic [31:0] d,
                                        input logic [31:0] s, input logic [8:0] pc,
                                        input logic [31:0] hr);
    logic [31:0] r;
    logic c;
    logic [32:0] w;
    logic [8:0] p1;
    c = 0; r = d;
    case (op)
      6'b000000: r = {24'd0, hr[7:0]};
      6'b000001: r = {16'd0, hr[15:0]};
      6'b000010: r = hr;
      6'b000011: r = {29'd0, d[2:0]};
      6'b010111: begin p1 = pc + 9'd1; r = {d[31:9], p1}; end
      6'b011000: begin r = d & s; c = ^r; end
      6'b011001: begin r = d & ~s; c = ^r; end
      6'b100001: begin r = d - s; c = (d < s); end
      6'b111100, 6'b111111: begin w = {1'b0, d} + {1'b0, s}; r = w[31:0]; c = w[32]; end
      6'b111101: begin w = {1'b0, d} + {1'b0, s} + 33'd1; r = w[31:0]; c = w[32]; end
      default: r = d;
    endcase
    return {(r == 0), c, r};
  endfunction

  task automatic issue(input logic [31:0] ins, input logic [31:0] d, input logic [31:0] sreg,
                       input logic [31:0] hr, input logic [31:0] pa, input logic [31:0] pb,
                       input logic [8:0] pc, input string tag);
    logic [5:0] op;
    logic [31:0] s;
    logic [33:0] m;
    bit pass, ishub, hit, eq;
    exp_t e;
    @(negedge clk);
    issue_valid = 1; issue_instr = ins; op_d = d; op_s_reg = sreg;
    hub_rdata = hr; pin_a = pa; pin_b = pb; issue_pc = pc;
    #1;
    op = ins[31:26];
    s = ins[22] ? {23'd0, ins[8:0]} : sreg;
    pass = ins[18 + {ec, ez}];
    ishub = (op == 6'b000000) || (op == 6'b000001) || (op == 6'b000010);
    chk(hub_wr == (pass && ishub && !ins[23]), {tag, " R2 hub_wr"}, hub_wr, pass && ishub && !ins[23]);
    chk(hub_rd == (pass && ishub && ins[23]), {tag, " R2 hub_rd"}, hub_rd, pass && ishub && ins[23]);
    if (pass && ishub) begin
      chk(hub_addr == s[15:0] && hub_wdata == d && hub_size == op[1:0], {tag, " R2 hub bus"},
          {hub_size, hub_addr, hub_wdata}, {op[1:0], s[15:0], d});
    end
    chk(jump_taken == (pass && op == 6'b010111), {tag, " R5 jump"}, jump_taken, pass && op == 6'b010111);
    if (pass && op == 6'b010111)
      chk(jump_target == s[8:0], {tag, " R5 target"}, jump_target, s[8:0]);
    eq = (((ec ? pb : pa) & s) == d);
    hit = pass && ((op == 6'b111100 && eq) || (op == 6'b111101 && !eq));
    chk(wait_hit == hit, {tag, " R7 wait_hit"}, wait_hit, hit);
    m = model(op, d, s, pc, hr);
    e.we = pass && ins[23];
    e.addr = ins[17:9];
    e.data = m[31:0];
    if (pass && ins[25]) ez = m[33];
    if (pass && ins[24]) ec = m[32];
    e.z = ez; e.c = ec; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    issue_valid = 0;
    op_s_reg = 32'hDEAD_BEEF;
    e.we = 0; e.addr = 0; e.data = 0; e.z = ez; e.c = ec; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare each registered result one clock after issue
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(rf_we == e.we && (!e.we || (rf_waddr == e.addr && rf_wdata == e.data)),
          {e.tag, " R10 writeback"}, {rf_we, rf_waddr, rf_wdata}, {e.we, e.addr, e.data});
      chk(flag_z == e.z && flag_c == e.c, {e.tag, " R10 flags"}, {flag_z, flag_c}, {e.z, e.c});
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R10 act=hung exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; issue_valid = 0; issue_instr = 0; issue_pc = 0;
    op_d = 0; op_s_reg = 0; hub_rdata = 0; pin_a = 0; pin_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!rf_we && !flag_z && !flag_c, "R11 reset state", {rf_we, flag_z, flag_c}, 3'b000);

    // R3: subtract vs compare
    issue(mk(6'b100001,1,1,1,0,4'hF,9'd10,9'd0), 32'd5, 32'd7, 0,0,0,0, "R3 sub borrow");
    issue(mk(6'b100001,1,1,0,0,4'hF,9'd11,9'd0), 32'd9, 32'd9, 0,0,0,0, "R3 cmp equal");
    // R4: and/test, andn/testn
    issue(mk(6'b011000,1,1,1,0,4'hF,9'd12,9'd0), 32'h0000F0F0, 32'h0000FF00, 0,0,0,0, "R4 and");
    issue(mk(6'b011000,1,1,0,0,4'hF,9'd13,9'd0), 32'h1, 32'h3, 0,0,0,0, "R4 test");
    issue(mk(6'b011001,1,1,1,0,4'hF,9'd14,9'd0), 32'hFF, 32'h0F, 0,0,0,0, "R4 andn");
    issue(mk(6'b011001,1,1,0,0,4'hF,9'd15,9'd0), 32'hF, 32'hF, 0,0,0,0, "R4 testn");
    // R5: link with pc wrap, plain jump; R9 immediate target
    issue(mk(6'b010111,1,1,1,1,4'hF,9'd16,9'h055), 32'hAAAAAAAA, 32'h0, 0,0,0,9'h1FF, "R5 link wrap");
    issue(mk(6'b010111,0,0,0,1,4'hF,9'd17,9'h0AA), 32'h1234, 32'h0, 0,0,0,9'h010, "R5 jump");
    // R6: wait arithmetic
    issue(mk(6'b111100,1,1,1,0,4'hF,9'd18,9'd0), 32'hFFFFFFFF, 32'h1, 0,0,0,0, "R6 peq wrap");
    issue(mk(6'b111101,1,1,1,0,4'hF,9'd19,9'd0), 32'd10, 32'd5, 0,0,0,0, "R6 pne plus one");
    issue(mk(6'b111111,1,1,1,0,4'hF,9'd20,9'd0), 32'd3, 32'd4, 0,0,0,0, "R6 vid");
    issue(mk(6'b111100,0,0,0,0,4'hF,9'd21,9'd0), 32'd3, 32'd4, 0,0,0,0, "R6 peq no write");
    // R7: carry is 0 here -> port A
    issue(mk(6'b111100,0,0,0,0,4'hF,9'd0,9'd0), 32'h0F, 32'hFF, 0, 32'h0000A50F, 32'h0, 0, "R7 peq port A hit");
    issue(mk(6'b111101,0,0,0,0,4'hF,9'd0,9'd0), 32'h0F, 32'hFF, 0, 32'h0000A50F, 32'h0, 0, "R7 pne port A miss");
    // set C=1 (subtract with borrow), Z=0
    issue(mk(6'b100001,1,1,0,0,4'hF,9'd0,9'd0), 32'd1, 32'd2, 0,0,0,0, "R3 cmp set C");
    issue(mk(6'b111100,0,0,0,0,4'hF,9'd0,9'd0), 32'h0F, 32'hFF, 0, 32'h0000A50F, 32'h3, 0, "R7 peq port B miss");
    issue(mk(6'b111101,0,0,0,0,4'hF,9'd0,9'd0), 32'h0F, 32'hFF, 0, 32'h0000A50F, 32'h3, 0, "R7 pne port B hit");
    // R2: hub pairs
    issue(mk(6'b000000,0,0,0,0,4'hF,9'd22,9'd0), 32'hCAFE0001, 32'h00001234, 32'h12345678,0,0,0, "R2 byte write");
    issue(mk(6'b000000,1,1,1,0,4'hF,9'd23,9'd0), 32'h0, 32'h00000040, 32'h12345678,0,0,0, "R2 byte read");
    issue(mk(6'b000001,0,0,0,0,4'hF,9'd24,9'd0), 32'h11, 32'h00000080, 32'h12345678,0,0,0, "R2 word write");
    issue(mk(6'b000001,1,1,1,0,4'hF,9'd25,9'd0), 32'h0, 32'h00000082, 32'h12345678,0,0,0, "R2 word read");
    issue(mk(6'b000010,0,0,0,0,4'hF,9'd26,9'd0), 32'h22, 32'h00000100, 32'h87654321,0,0,0, "R2 long write");
    issue(mk(6'b000010,1,1,1,0,4'hF,9'd27,9'd0), 32'h0, 32'h00000104, 32'h87654321,0,0,0, "R2 long read");
    issue(mk(6'b000000,1,1,1,0,4'hF,9'd28,9'd0), 32'h0, 32'h0, 32'hFFFFFF00,0,0,0, "R2 byte read zero");
    // R8: control group
    issue(mk(6'b000011,1,1,1,0,4'hF,9'd29,9'd0), 32'h1234567D, 32'h0, 0,0,0,0, "R8 sys write");
    issue(mk(6'b000011,1,1,0,0,4'hF,9'd30,9'd0), 32'h12345678, 32'h0, 0,0,0,0, "R8 sys no write");
    // R9: immediate ignores source register
    issue(mk(6'b100001,1,1,1,1,4'hF,9'd31,9'h1FF), 32'h200, 32'hFFFFFFFF, 0,0,0,0, "R9 imm sub");
    // R1: conditions. Flags now Z=0,C=0.
    issue(mk(6'b100001,1,1,1,0,4'h0,9'd32,9'd0), 32'd5, 32'd1, 0,0,0,0, "R1 never");
    issue(mk(6'b100001,1,1,0,0,4'hF,9'd0,9'd0), 32'd4, 32'd4, 0,0,0,0, "R1 set Z");
    issue(mk(6'b011000,0,0,1,0,4'b0010,9'd33,9'd0), 32'hF, 32'h3, 0,0,0,0, "R1 cond Z only pass");
    issue(mk(6'b011000,1,1,1,0,4'b1101,9'd34,9'd0), 32'hF, 32'h3, 0,0,0,0, "R1 cond Z only fail");
    // R10: write without flag update
    issue(mk(6'b100001,0,0,1,0,4'hF,9'd35,9'd0), 32'd1, 32'd2, 0,0,0,0, "R10 no flag bits");
    issue(mk(6'b100001,0,1,0,0,4'hF,9'd0,9'd0), 32'd1, 32'd2, 0,0,0,0, "R10 carry only");
    idle("R10 idle hold");
    idle("R10 idle hold 2");
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule